// File: doc/BRIEF.md
# Transmit phase align buffer

This block carries 10-bit transmit characters from a source clock into the character-rate clock of a serial transmitter. Both clocks run at the same frequency, but the phase of the source clock is unknown and may wander. A small ring of storage absorbs the phase difference. The write side advances a Gray-coded pointer. The read side synchronizes that pointer through two flops, works out how full the ring looks, and reads one character per cycle.

An initialization request places the read pointer at a fixed distance behind the synchronized write pointer. If the apparent fill level later leaves its allowed window, the block raises `tx_err` and holds it. While `tx_err` is high, the character output carries a violation code in place of buffered data, so the far end can see that the link is broken. The error clears only in two ways. One is a new initialization request. The other is a complete run of consecutive word-sync characters written while the error is present, which recentres the ring. Recentring may add or remove only fill (sync) characters.

Top module: `tx_phase_align`

## Requirements
- R1: After reset, `tx_err` is 1 and `rd_char` holds the violation code (default 10'h3A7). Both stay that way until an initialization request arrives.
- R2: The rising clock edge that samples `init_req` high clears `tx_err`. If the error was set, the output from that edge is the fill code (default 10'h2FC).
- R3: While `tx_err` is 0, each character written appears exactly once on `rd_char`, in write order. No character is duplicated or dropped.
- R4: After initialization, the write clock phase may drift by up to half a character period either way without raising `tx_err` or losing a character.
- R5: One missing write is tolerated. If writes stop long enough that the synchronized fill level falls below -1 (a gap of 8 characters is enough), `tx_err` is set.
- R6: If writes get ahead of reads so that the synchronized fill level rises above DEPTH-4, `tx_err` is set.
- R7: Once set, `tx_err` stays 1 until an initialization or a completed word sync. While it is 1, `rd_char` carries the violation code.
- R8: While `tx_err` is 1, a run of SYNC_LEN (default 16) consecutive valid characters marked with `wr_sync` recentres the ring and clears `tx_err`. A run that is one character short does not.
- R9: A complete word-sync run while `tx_err` is 0 does not move the read pointer. The data stream stays intact.
- R10: An initialization request issued while the stream runs at its centred level does not duplicate or drop any data character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Per-channel asynchronous reset, active low |
| wr_clk | input | 1 | Source (input) character clock |
| wr_valid | input | 1 | Writes `wr_char` on this `wr_clk` edge |
| wr_char | input | 10 | Character to transmit |
| wr_sync | input | 1 | Marks `wr_char` as part of a word-sync run |
| rd_clk | input | 1 | Internal character-rate clock |
| init_req | input | 1 | Recentre request, sampled on `rd_clk` |
| rd_char | output | 10 | Character to the encoder: data, fill or violation code |
| tx_err | output | 1 | Sticky phase error; high means data may have been lost |

## Verification
The hardest state to reach from the ports is an overflow. Both clocks nominally run at the same rate, so the write side only gets ahead if its clock actually runs faster. The bench shortens the write clock period for a stretch, which lets the writes overtake the reads until the error latches. It then restores the period and feeds sync runs of 15 and then 16 characters, to show that only a full run recentres. Phase drift is produced the same way, by stretching and then shrinking single half-periods, so that the write edge sweeps through plus and minus 4 ns around its starting point while a running sequence check looks for gaps or repeats.

// File: rtl/tx_phase_align.sv
module tx_phase_align #(
  parameter int W = 10,
  parameter int DEPTH = 8,
  parameter int SYNC_LEN = 16,
  parameter int CENTER = 2,
  parameter logic [W-1:0] FILL_CODE = 10'h2FC,
  parameter logic [W-1:0] VIOL_CODE = 10'h3A7
) (
  input  logic         rst_n,
  input  logic         wr_clk,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_char,
  input  logic         wr_sync,
  input  logic         rd_clk,
  input  logic         init_req,
  output logic [W-1:0] rd_char,
  output logic         tx_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int SW = $clog2(SYNC_LEN + 1);
  localparam logic signed [PW-1:0] FILL_LO = '1;
  localparam logic signed [PW-1:0] FILL_HI = PW'(DEPTH - 4);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  ring [DEPTH];
  logic [PW-1:0] wr_bin, wr_gray;
  logic [SW-1:0] sync_run;
  logic          sync_tgl;

  always_ff @(posedge wr_clk) begin
    if (wr_valid) ring[wr_bin[AW-1:0]] <= wr_char;
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin   <= '0;
      wr_gray  <= '0;
      sync_run <= '0;
      sync_tgl <= 1'b0;
    end else if (wr_valid) begin
      wr_bin  <= wr_bin + 1'b1;
      wr_gray <= to_gray(wr_bin + 1'b1);
      if (!wr_sync) begin
        sync_run <= '0;
      end else if (sync_run == SW'(SYNC_LEN - 1)) begin
        sync_run <= '0;
        sync_tgl <= ~sync_tgl;
      end else begin
        sync_run <= sync_run + 1'b1;
      end
    end
  end

  logic [PW-1:0] wg_s1, wg_s2, rd_bin, ws_bin;
  logic [2:0]    tg_s;
  logic signed [PW-1:0] fill;
  logic          err, sync_evt, recentre, out_range;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      wg_s1 <= '0;
      wg_s2 <= '0;
      tg_s  <= '0;
    end else begin
      wg_s1 <= wr_gray;
      wg_s2 <= wg_s1;
      tg_s  <= {tg_s[1:0], sync_tgl};
    end
  end

  assign ws_bin    = from_gray(wg_s2);
  assign fill      = ws_bin - rd_bin;
  assign sync_evt  = tg_s[2] ^ tg_s[1];
  assign recentre  = init_req | (err & sync_evt);
  assign out_range = (fill < FILL_LO) || (fill > FILL_HI);

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin  <= '0;
      err     <= 1'b1;
      rd_char <= VIOL_CODE;
    end else if (recentre) begin
      rd_bin  <= ws_bin - PW'(CENTER - 1);
      err     <= 1'b0;
      rd_char <= err ? FILL_CODE : ring[rd_bin[AW-1:0]];
    end else begin
      rd_bin  <= rd_bin + 1'b1;
      err     <= err | out_range;
      rd_char <= (err | out_range) ? VIOL_CODE : ring[rd_bin[AW-1:0]];
    end
  end

  assign tx_err = err;

  p_gray_step_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  p_init_clears_r2: assert property (@(posedge rd_clk) disable iff (!rst_n)
    init_req |=> !tx_err);

  p_err_sticky_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (tx_err && !init_req && !sync_evt) |=> tx_err);

  p_viol_out_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (tx_err && !init_req && !sync_evt) |=> rd_char == VIOL_CODE);

  p_sync_recover_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (tx_err && sync_evt) |=> (!tx_err && rd_char == FILL_CODE));

  p_sync_ignored_r9: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!tx_err && sync_evt && !init_req) |=> rd_bin == $past(rd_bin) + 1'b1);
endmodule

// File: tb/test_tx_phase_align.sv
`timescale 1ns/1ps
module test_tx_phase_align;
  localparam logic [9:0] FILL = 10'h2FC;
  localparam logic [9:0] VIOL = 10'h3A7;

  logic rst_n = 1'b0, wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_valid = 1'b0, wr_sync = 1'b0, init_req = 1'b0;
  logic [9:0] wr_char = '0;
  logic [9:0] rd_char;
  logic tx_err;

  tx_phase_align #(.W(10), .DEPTH(8), .SYNC_LEN(16), .CENTER(2),
                   .FILL_CODE(FILL), .VIOL_CODE(VIOL)) i_tx_phase_align (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_valid(wr_valid), .wr_char(wr_char),
    .wr_sync(wr_sync), .rd_clk(rd_clk), .init_req(init_req),
    .rd_char(rd_char), .tx_err(tx_err));

  int checks = 0, errors = 0;
  real wr_half = 5.0;
  int gap_left = 0, sync_left = 0;
  logic [8:0] wcnt = '0;
  int seq_bad = 0, data_seen = 0;
  logic [8:0] prev = '0;
  bit have_prev = 0;
  bit done = 0;

  always #5 rd_clk = ~rd_clk;
  initial begin
    #3;
    forever #(wr_half) wr_clk = ~wr_clk;
  end

  always @(negedge wr_clk) begin
    if (gap_left > 0) begin
      wr_valid <= 1'b0;
      gap_left = gap_left - 1;
    end else if (sync_left > 0) begin
      wr_valid <= 1'b1;
      wr_sync  <= 1'b1;
      wr_char  <= FILL;
      sync_left = sync_left - 1;
    end else begin
      wr_valid <= 1'b1;
      wr_sync  <= 1'b0;
      wr_char  <= {1'b0, wcnt};
      wcnt = wcnt + 9'd1;
    end
  end

  always @(negedge rd_clk) begin
    if (!rst_n || tx_err) begin
      have_prev = 0;
    end else if (!rd_char[9]) begin
      if (have_prev && rd_char[8:0] != prev + 9'd1) seq_bad++;
      prev = rd_char[8:0];
      have_prev = 1;
      data_seen++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_rd(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    wait_rd(4);
    check(tx_err == 1'b1, "R1 err in reset", tx_err, 1);
    check(rd_char == VIOL, "R1 viol in reset", rd_char, VIOL);
    rst_n = 1'b1;
    wait_rd(10);
    check(tx_err == 1'b1, "R1 err held before init", tx_err, 1);
    check(rd_char == VIOL, "R1 viol held before init", rd_char, VIOL);
  endtask

  task automatic t_init_from_err;
    init_req = 1'b1;
    @(negedge rd_clk);
    init_req = 1'b0;
    check(tx_err == 1'b0, "R2 init clears err", tx_err, 0);
    check(rd_char == FILL, "R2 fill after init", rd_char, FILL);
    wait_rd(10);
  endtask

  task automatic t_stream;
    int b, d;
    b = seq_bad; d = data_seen;
    wait_rd(100);
    check(seq_bad == b, "R3 stream order", seq_bad - b, 0);
    check(data_seen - d == 100, "R3 one char per cycle", data_seen - d, 100);
    check(tx_err == 1'b0, "R3 no err", tx_err, 0);
  endtask

  task automatic t_init_steady;
    int b, d;
    b = seq_bad; d = data_seen;
    init_req = 1'b1;
    @(negedge rd_clk);
    init_req = 1'b0;
    wait_rd(29);
    check(tx_err == 1'b0, "R10 err stays low", tx_err, 0);
    check(seq_bad == b, "R10 no loss on init", seq_bad - b, 0);
    check(data_seen - d == 30, "R10 no fill inserted", data_seen - d, 30);
  endtask

  task automatic t_drift;
    int b;
    b = seq_bad;
    wr_half = 5.05; repeat (40) @(posedge wr_clk);
    wr_half = 4.95; repeat (80) @(posedge wr_clk);
    wr_half = 5.05; repeat (40) @(posedge wr_clk);
    wr_half = 5.0;
    wait_rd(20);
    check(tx_err == 1'b0, "R4 drift tolerated", tx_err, 0);
    check(seq_bad == b, "R4 drift no loss", seq_bad - b, 0);
  endtask

  task automatic t_gap1;
    int b;
    b = seq_bad;
    gap_left = 1;
    wait_rd(30);
    check(tx_err == 1'b0, "R5 single gap tolerated", tx_err, 0);
    check(seq_bad == b, "R5 single gap order", seq_bad - b, 0);
  endtask

  task automatic t_underflow;
    gap_left = 8;
    wait_rd(25);
    check(tx_err == 1'b1, "R5 underflow sets err", tx_err, 1);
    wait_rd(40);
    check(tx_err == 1'b1, "R7 err sticky", tx_err, 1);
    check(rd_char == VIOL, "R7 viol while err", rd_char, VIOL);
  endtask

  task automatic t_recover_init;
    int b;
    t_init_from_err();
    b = seq_bad;
    wait_rd(50);
    check(seq_bad == b && tx_err == 1'b0, "R3 order after re-init", seq_bad - b, 0);
  endtask

  task automatic t_overflow;
    wr_half = 4.0;
    repeat (40) @(posedge wr_clk);
    wr_half = 5.0;
    wait_rd(10);
    check(tx_err == 1'b1, "R6 overflow sets err", tx_err, 1);
    wait_rd(30);
    check(rd_char == VIOL, "R7 viol after overflow", rd_char, VIOL);
  endtask

  task automatic t_sync_short;
    sync_left = 15;
    wait_rd(50);
    check(tx_err == 1'b1, "R8 short sync ignored", tx_err, 1);
  endtask

  task automatic t_sync_full;
    int b;
    sync_left = 16;
    wait_rd(30);
    check(tx_err == 1'b0, "R8 full sync clears err", tx_err, 0);
    b = seq_bad;
    wait_rd(50);
    check(seq_bad == b && tx_err == 1'b0, "R8 order after sync", seq_bad - b, 0);
  endtask

  task automatic t_sync_idle;
    int b;
    b = seq_bad;
    sync_left = 16;
    wait_rd(60);
    check(tx_err == 1'b0, "R9 sync without err", tx_err, 0);
    check(seq_bad == b, "R9 stream intact", seq_bad - b, 0);
  endtask

  initial begin
    @(negedge rd_clk);
    t_reset();
    t_init_from_err();
    t_stream();
    t_init_steady();
    t_drift();
    t_gap1();
    t_underflow();
    t_recover_init();
    t_overflow();
    t_sync_short();
    t_sync_full();
    t_sync_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule